// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the device half of a receive descriptor ring kept in a word-addressed memory that it shares with software. Software prepares descriptors of four 32-bit words each: a status word, a control word carrying a buffer size and two chaining flags, a buffer address and a next-descriptor pointer. All addresses are word addresses. When the engine finds a descriptor that it owns, it stores the next complete frame from a byte stream into that descriptor's buffer. It then writes a status word back, which returns the descriptor to software, and moves on to the following descriptor.

The ring starts at `ring_base`. After each frame, one of two control flags chooses the next descriptor: the wrap flag sends the engine back to the ring base, and the chain flag makes it follow the pointer word. With neither flag set, the next descriptor follows directly after the current one in memory. If the descriptor at hand still belongs to software, the engine goes idle and discards whole frames. It looks at the descriptor again only when software pulses the poll-demand input.

The memory port uses registered outputs and a synchronous single-port memory: read data is valid one clock after the request is presented. The byte stream has no back-pressure. Bytes that arrive while the engine cannot take them are lost.

Top module: `rx_desc_engine`

## Requirements
- R1: After reset the engine is suspended at `ring_base` and makes no memory access until `poll_req` is pulsed.
- R2: A `poll_req` pulse while suspended makes the engine read the four words of the current descriptor. If status bit 31 is 1 the engine becomes ready to receive; otherwise it stays suspended. `poll_req` has no effect in any other state.
- R3: Frame byte i is stored in buffer word (buffer address + i/4) at bits 8*(i mod 4)+7 down to 8*(i mod 4). In the last word written, the byte lanes above the final stored byte are written as zero.
- R4: The status write-back word has bit 31 = 0 (ownership returned), bit 30 = 1 and bit 8 = 1 (single-buffer frame), bits 29:16 = the number of frame bytes received (FCS included), and all bits other than 15 otherwise zero.
- R5: Status bit 15 is set when `rx_err` was high on any byte of the frame.
- R6: Bytes at index equal to or above the buffer size (control bits 10:0) are not written to memory. The frame still counts them in bits 29:16 and sets bit 15.
- R7: The status write-back happens in a later cycle than the last buffer write of the same frame.
- R8: After write-back, the next descriptor is `ring_base` if control bit 25 is set. Otherwise it is the address in word 3 if control bit 24 is set. Otherwise it is the current address + 4.
- R9: A frame whose first byte arrives while the engine is not ready is dropped entirely, even if the engine becomes ready while that frame is still arriving. A dropped frame causes no memory write.
- R10: After a write-back the engine fetches the next descriptor without waiting for `poll_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | AW | Word address of the first descriptor of the ring |
| poll_req | input | 1 | Poll-demand strobe, one cycle |
| rx_valid | input | 1 | Frame byte present this cycle |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| rx_err | input | 1 | Receive error reported with this byte |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after a read |

## Verification
The bench aims at these cases:
- A frame that overruns its buffer by an odd number of bytes. A design that lost the pending partial word, or wrote past the limit, would leave the wrong contents next to the buffer boundary.
- A frame that starts while the engine is suspended and is still arriving when a poll makes the engine ready. A design that took the tail of that frame would report a bogus length.
- Descriptors with the wrap flag, with the chain flag and with neither flag. A wrong choice shows up as a read of the wrong descriptor address right after write-back.
- An error flag on a single middle byte, and the order of the final data write against the status write. Either one separates a design that samples the flag only at the frame end, or that writes status too early.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [2:0] {
    ST_SUSP,
    ST_FETCH,
    ST_WAIT,
    ST_RECV,
    ST_WB
  } rxd_state_e;

  localparam int OWN_BIT    = 31;
  localparam int FIRST_BIT  = 30;
  localparam int ERR_BIT    = 15;
  localparam int LAST_BIT   = 8;
  localparam int WRAP_BIT   = 25;
  localparam int CHAIN_BIT  = 24;
  localparam int LEN_LSB    = 16;
  localparam int DESC_WORDS = 4;
endpackage

// File: rtl/rxd_byte_packer.sv
module rxd_byte_packer #(
  parameter int AW     = 12,
  parameter int LEN_W  = 14,
  parameter int SIZE_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              byte_en,
  input  logic [7:0]        byte_in,
  input  logic              last_in,
  input  logic [SIZE_W-1:0] buf_size,
  input  logic [AW-1:0]     buf_base,
  output logic              wr_req,
  output logic [AW-1:0]     wr_addr,
  output logic [31:0]       wr_data,
  output logic [LEN_W-1:0]  byte_cnt,
  output logic              ovf
);
  localparam int LANES = 4;

  logic [31:0]      pack_q;
  logic [LEN_W-1:0] size_ext;
  logic             in_lim;
  logic             end_of_buf;
  logic [1:0]       lane;

  assign size_ext   = LEN_W'(buf_size);
  assign in_lim     = byte_cnt < size_ext;
  assign end_of_buf = byte_cnt == (size_ext - LEN_W'(1));
  assign lane       = byte_cnt[1:0];
  assign wr_req     = byte_en && in_lim && (lane == 2'd3 || last_in || end_of_buf);
  assign wr_addr    = buf_base + AW'(byte_cnt >> 2);

  always_comb begin
    wr_data = '0;
    for (int k = 0; k < LANES; k++) begin
      if (k < int'(lane))       wr_data[8*k +: 8] = pack_q[8*k +: 8];
      else if (k == int'(lane)) wr_data[8*k +: 8] = byte_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      byte_cnt <= '0;
      ovf      <= 1'b0;
      pack_q   <= '0;
    end else if (byte_en) begin
      if (in_lim) pack_q[8*lane +: 8] <= byte_in;
      else        ovf <= 1'b1;
      if (byte_cnt != '1) byte_cnt <= byte_cnt + LEN_W'(1);
    end
  end

  AST_OVF_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (ovf && byte_en && !clr) |-> !wr_req); // R6
endmodule

// File: rtl/rxd_ring_step.sv
module rxd_ring_step #(
  parameter int AW = 12
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] base,
  input  logic [31:0]   ctl,
  input  logic [31:0]   chain_ptr,
  output logic [AW-1:0] nxt
);
  import rxd_pkg::*;

  always_comb begin
    if (ctl[WRAP_BIT])       nxt = base;
    else if (ctl[CHAIN_BIT]) nxt = chain_ptr[AW-1:0];
    else                     nxt = cur + AW'(DESC_WORDS);
  end
endmodule

// File: rtl/rx_desc_engine.sv
module rx_desc_engine #(
  parameter int AW     = 12,
  parameter int LEN_W  = 14,
  parameter int SIZE_W = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ring_base,
  input  logic          poll_req,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  input  logic          rx_err,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);
  import rxd_pkg::*;

  localparam int FC_W      = 3;
  localparam int FETCH_END = DESC_WORDS + 1;

  rxd_state_e       state;
  logic [AW-1:0]    cur_q;
  logic [FC_W-1:0]  fcnt;
  logic             own_q;
  logic [31:0]      ctl_q;
  logic [AW-1:0]    buf_q;
  logic [31:0]      nxt_q;
  logic             ferr_q;
  logic             mid_q;

  logic             accept;
  logic             pk_clr;
  logic             pk_wr;
  logic [AW-1:0]    pk_addr;
  logic [31:0]      pk_data;
  logic [LEN_W-1:0] pk_cnt;
  logic             pk_ovf;
  logic [AW-1:0]    next_desc;
  logic [31:0]      st_word;

  assign accept = rx_valid && ((state == ST_WAIT && !mid_q) || state == ST_RECV);
  assign pk_clr = (state == ST_FETCH) && (fcnt == FC_W'(FETCH_END));

  rxd_byte_packer #(.AW(AW), .LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_pack (
    .clk(clk), .rst(rst), .clr(pk_clr),
    .byte_en(accept), .byte_in(rx_data), .last_in(rx_last),
    .buf_size(ctl_q[SIZE_W-1:0]), .buf_base(buf_q),
    .wr_req(pk_wr), .wr_addr(pk_addr), .wr_data(pk_data),
    .byte_cnt(pk_cnt), .ovf(pk_ovf)
  );

  rxd_ring_step #(.AW(AW)) u_step (
    .cur(cur_q), .base(ring_base), .ctl(ctl_q), .chain_ptr(nxt_q), .nxt(next_desc)
  );

  always_comb begin
    st_word = '0;
    st_word[FIRST_BIT]            = 1'b1;
    st_word[LAST_BIT]             = 1'b1;
    st_word[ERR_BIT]              = ferr_q | pk_ovf;
    st_word[LEN_LSB +: LEN_W]     = pk_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_SUSP;
      cur_q     <= ring_base;
      fcnt      <= '0;
      own_q     <= 1'b0;
      ctl_q     <= '0;
      buf_q     <= '0;
      nxt_q     <= '0;
      ferr_q    <= 1'b0;
      mid_q     <= 1'b0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_en <= 1'b0;
      mem_we <= 1'b0;
      if (rx_valid) mid_q <= !rx_last;
      if (pk_wr) begin
        mem_en    <= 1'b1;
        mem_we    <= 1'b1;
        mem_addr  <= pk_addr;
        mem_wdata <= pk_data;
      end
      unique case (state)
        ST_SUSP: begin
          if (poll_req) begin
            state <= ST_FETCH;
            fcnt  <= '0;
          end
        end
        ST_FETCH: begin
          if (fcnt < FC_W'(DESC_WORDS)) begin
            mem_en   <= 1'b1;
            mem_addr <= cur_q + AW'(fcnt);
          end
          case (fcnt)
            3'd2:    own_q <= mem_rdata[OWN_BIT];
            3'd3:    ctl_q <= mem_rdata;
            3'd4:    buf_q <= mem_rdata[AW-1:0];
            3'd5:    nxt_q <= mem_rdata;
            default: ;
          endcase
          if (fcnt == FC_W'(FETCH_END)) begin
            state  <= own_q ? ST_WAIT : ST_SUSP;
            ferr_q <= 1'b0;
          end else begin
            fcnt <= fcnt + FC_W'(1);
          end
        end
        ST_WAIT, ST_RECV: begin
          if (accept) begin
            ferr_q <= ferr_q | rx_err;
            state  <= rx_last ? ST_WB : ST_RECV;
          end
        end
        ST_WB: begin
          mem_en    <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= cur_q;
          mem_wdata <= st_word;
          cur_q     <= next_desc;
          fcnt      <= '0;
          state     <= ST_FETCH;
        end
        default: state <= ST_SUSP;
      endcase
    end
  end

  AST_POLL_RESUME: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SUSP && poll_req) |=> (state == ST_FETCH)); // R2
  AST_SUSP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SUSP && $past(state) == ST_SUSP) |-> !mem_en); // R9
  AST_STATUS_HANDBACK: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_WB) |-> (mem_we && !mem_wdata[OWN_BIT] && mem_wdata[FIRST_BIT] && mem_wdata[LAST_BIT])); // R4
  AST_AUTO_FETCH: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WB) |=> (state == ST_FETCH)); // R10
endmodule

// File: tb/sim_rx_desc_engine.sv
module sim_rx_desc_engine;
  localparam int AW = 12;
  localparam int BUF1 = 1024;
  localparam int BUF2 = 2048;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] ring_base = '0;
  logic          poll_req = 1'b0;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_data = '0;
  logic          rx_last = 1'b0;
  logic          rx_err = 1'b0;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata = '0;

  logic [31:0] mem [0:(1<<AW)-1];
  logic [7:0]  fb [0:2047];
  int n_chk = 0, n_bad = 0;
  int cyc = 0, last_data_cyc = 0, st_cyc = 0, first_rd = -1, en_cnt = 0;
  bit arm = 0;

  always #5 clk = ~clk;

  rx_desc_engine #(.AW(AW)) u0 (
    .clk(clk), .rst(rst), .ring_base(ring_base), .poll_req(poll_req),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst && mem_en) begin
      en_cnt <= en_cnt + 1;
      if (mem_we) begin
        if (int'(mem_addr) >= BUF1) last_data_cyc <= cyc;
        else begin st_cyc <= cyc; arm <= 1'b1; end
      end else if (arm) begin
        first_rd <= int'(mem_addr);
        arm <= 1'b0;
      end
    end
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sent(input int i);
    return 32'hA500_0000 | i;
  endfunction

  task automatic fill_buf(input int base);
    for (int i = 0; i < 400; i++) mem[base+i] = sent(i);
  endtask

  task automatic set_desc(input int a, input bit own, input logic [31:0] ctl, input int bufa, input int nxt);
    mem[a]   = own ? 32'h8000_0000 : 32'h0;
    mem[a+1] = ctl;
    mem[a+2] = bufa;
    mem[a+3] = nxt;
  endtask

  task automatic make_frame(input int len);
    for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
  endtask

  task automatic send(input int len, input int errpos, input int pollpos);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = fb[i];
      rx_last = (i == len-1); rx_err = (i == errpos);
      poll_req = (i == pollpos);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0; poll_req = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic poll();
    @(negedge clk); poll_req = 1'b1;
    @(negedge clk); poll_req = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_status(input int len, input bit err);
    return 32'h4000_0100 | (32'(len) << 16) | (32'(err) << 15);
  endfunction

  task automatic check_frame(input string req, input int d, input int bufa, input int len,
                             input int size, input bit err);
    int n, words, badw;
    logic [31:0] e, a;
    n = (len < size) ? len : size;
    words = (n + 3) / 4;
    badw = -1; e = '0; a = '0;
    for (int j = 0; j < words; j++) begin
      logic [31:0] x;
      x = '0;
      for (int k = 0; k < 4; k++) if (4*j+k < n) x[8*k +: 8] = fb[4*j+k];
      if (badw < 0 && mem[bufa+j] !== x) begin badw = j; e = x; a = mem[bufa+j]; end
    end
    chk(badw < 0, {req, " R3 buffer data"}, a, e);
    chk(mem[bufa+words] === sent(words), {req, " R6 word past data untouched"}, mem[bufa+words], sent(words));
    chk(mem[d] === exp_status(len, err), {req, " R4 status word"}, mem[d], exp_status(len, err));
    chk(st_cyc > last_data_cyc, {req, " R7 status after data"}, st_cyc, last_data_cyc);
  endtask

  initial begin
    int la, lb, sa, sb, ea, eb;
    logic [31:0] keep;
    void'($urandom(32'd4242));
    for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
    fill_buf(BUF1); fill_buf(BUF2);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    chk(en_cnt == 0, "R1 no access before poll", en_cnt, 0);

    // R2 R9: descriptor owned by software, engine suspends and drops
    set_desc(0, 0, 32'h0100_0600, BUF1, 8);
    poll();
    chk(en_cnt == 4, "R2 four descriptor reads", en_cnt, 4);
    make_frame(50); send(50, -1, -1);
    chk(mem[0] === 32'h0, "R9 status untouched when not owned", mem[0], 0);
    chk(mem[BUF1] === sent(0), "R9 buffer untouched when not owned", mem[BUF1], sent(0));

    // R3 R4 R8 R10: chained A -> B, B wraps
    set_desc(0, 1, 32'h0100_0600, BUF1, 8);
    set_desc(8, 1, 32'h0200_0600, BUF2, 0);
    poll();
    make_frame(101); send(101, -1, -1);
    check_frame("A1", 0, BUF1, 101, 1536, 0);
    chk(first_rd == 8, "R8 chain pointer followed", first_rd, 8);
    keep = mem[0];
    make_frame(64); send(64, 10, -1);
    check_frame("B1 R10 R5", 8, BUF2, 64, 1536, 1);
    chk(first_rd == 0, "R8 wrap to ring base", first_rd, 0);
    make_frame(30); send(30, -1, -1);
    chk(mem[0] === keep, "R9 frame dropped after wrap", mem[0], keep);

    // R6: overflow, odd size
    fill_buf(BUF1);
    set_desc(0, 1, 32'h0200_0025, BUF1, 0);
    poll();
    make_frame(60); send(60, -1, -1);
    check_frame("OVF R6", 0, BUF1, 60, 37, 1);

    // R8: no chaining flags -> contiguous next
    fill_buf(BUF1); fill_buf(BUF2);
    set_desc(0, 1, 32'h0000_0064, BUF1, 8);
    set_desc(4, 1, 32'h0200_00C8, BUF2, 0);
    poll();
    make_frame(30); send(30, -1, -1);
    check_frame("SEQ", 0, BUF1, 30, 100, 0);
    chk(first_rd == 4, "R8 contiguous next descriptor", first_rd, 4);
    make_frame(41); send(41, -1, -1);
    check_frame("SEQ2", 4, BUF2, 41, 200, 0);

    // R9: frame under way when engine becomes ready is dropped whole
    fill_buf(BUF1);
    set_desc(0, 1, 32'h0200_0600, BUF1, 0);
    make_frame(40); send(40, -1, 5);
    chk(mem[BUF1] === sent(0), "R9 tail of early frame dropped", mem[BUF1], sent(0));
    make_frame(33); send(33, -1, -1);
    check_frame("LATE R9", 0, BUF1, 33, 1536, 0);

    // random pairs
    for (int it = 0; it < 12; it++) begin
      fill_buf(BUF1); fill_buf(BUF2);
      sa = 1 + int'($urandom % 1536); sb = 1 + int'($urandom % 1536);
      la = 1 + int'($urandom % 1600); lb = 1 + int'($urandom % 1600);
      ea = ($urandom % 3 == 0) ? int'($urandom % la) : -1;
      eb = ($urandom % 3 == 0) ? int'($urandom % lb) : -1;
      set_desc(0, 1, 32'h0100_0000 | sa, BUF1, 8);
      set_desc(8, 1, 32'h0200_0000 | sb, BUF2, 0);
      poll();
      make_frame(la); send(la, ea, -1);
      check_frame("RND A R5 R6", 0, BUF1, la, sa, (ea >= 0) || (la > sa));
      make_frame(lb); send(lb, eb, -1);
      check_frame("RND B R5 R6", 8, BUF2, lb, sb, (eb >= 0) || (lb > sb));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule